// File: doc/BRIEF.md
# Flash Program and Erase Cycle Sequencer

This block carries out the internal write cycles of a serial flash array built from sectors of pages of bytes (by default 4 sectors of 256 pages of 256 bytes, 256 KB in all). A command front end handles the serial framing and the address protection decode. It tells this block when a frame starts, hands over each received data byte, and presents the finished command on the clock where chip select rises. The command carries an operation code, the number of bits clocked in the frame, the target address, the write-enable latch level and the protection status.

If the command ends on a legal bit boundary, the latch is set and protection allows it, the block goes busy. It waits a self-timed interval whose length in clock cycles depends on the operation. It then writes the array through a byte-wide memory port, one byte per clock. Programming only clears bits, because each stored byte becomes the old value ANDed with the new one. Erase fills its region with 0xFF. On the last write clock the block pulses a done flag and a clear request for the write-enable latch.

Top module: `flash_wr_seq`

## Requirements
- R1: A command is accepted only when its bit count matches its operation. Operation codes are 0 for program, 1 for page erase, 2 for sector erase and 3 for whole-array erase. Program needs a count of at least 40 that is a multiple of 8. Page and sector erase need exactly 32. Whole-array erase needs exactly 8.
- R2: A command presented with `wel_i` low has no effect: busy stays low and no byte of the array changes.
- R3: Program, page erase and sector erase are dropped when `prot_hit_i` is high. Whole-array erase runs only when `bp_none_i` is high.
- R4: After an accepted command, `busy_o` is high from the next clock for exactly T+L cycles. T is the operation's wait parameter. L is the page size for program and page erase, the sector size for sector erase and the array size for whole-array erase.
- R5: While `busy_o` is high, `cmd_valid_i`, `dat_valid_i` and `sel_start_i` are ignored.
- R6: Program stores the old byte ANDed with the buffered byte, so it never sets a bit.
- R7: Data byte i of a program frame goes to page offset (start offset + i) mod page size within the addressed page. A later byte that lands on the same offset replaces the earlier one.
- R8: Page erase sets the addressed page to 0xFF, sector erase the addressed sector, and whole-array erase every byte. Bytes outside the region keep their values.
- R9: `done_o` and `wel_clr_o` are high for exactly one cycle, which is the last busy cycle.
- R10: `mem_we_o` is high only while busy, during the write phase that follows the wait interval.
- R11: After reset, `busy_o`, `done_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_start_i | input | 1 | Frame start pulse; clears the page buffer |
| dat_valid_i | input | 1 | Data byte strobe during a program frame |
| dat_i | input | 8 | Received data byte |
| cmd_valid_i | input | 1 | Frame end pulse (chip select rose) |
| cmd_op_i | input | 2 | Operation code (0 program, 1 page erase, 2 sector erase, 3 whole-array erase) |
| cmd_bits_i | input | BIT_W | Bits clocked in the frame, opcode included |
| cmd_addr_i | input | ADDR_W | Target byte address |
| wel_i | input | 1 | Write-enable latch level |
| prot_hit_i | input | 1 | Target address lies in the protected range |
| bp_none_i | input | 1 | Both block-protect bits are zero |
| busy_o | output | 1 | Self-timed cycle in progress |
| done_o | output | 1 | Last cycle of the write phase |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_addr_o | output | ADDR_W | Array byte address (also read address) |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data at `mem_addr_o`, combinational |

## Verification
A wrong acceptance decision shows on `busy_o` at the first clock after the frame-end pulse, so it is visible one cycle after the command. A wrong timer or walker length moves the falling edge of `busy_o` and the single `done_o` pulse, and the clock-by-clock comparison against the busy window catches this on the first cycle that differs. A corrupted page buffer slot, a wrong wrap offset or a wrong erase base shows only in the array contents. These are compared byte for byte on the clock after the write phase ends.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PERASE = 2'd1,
    OP_SERASE = 2'd2,
    OP_BULK   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;
endpackage

// File: rtl/fws_gate.sv
module fws_gate import fws_pkg::*; #(
  parameter int BIT_W = 16
) (
  input  logic             valid_i,
  input  logic             busy_i,
  input  op_e              op_i,
  input  logic [BIT_W-1:0] bits_i,
  input  logic             wel_i,
  input  logic             prot_hit_i,
  input  logic             bp_none_i,
  output logic             accept_o
);
  localparam logic [BIT_W-1:0] BITS_OPC  = BIT_W'(8);
  localparam logic [BIT_W-1:0] BITS_ADDR = BIT_W'(32);
  localparam logic [BIT_W-1:0] BITS_MIN  = BIT_W'(40);

  logic edge_ok, region_ok;

  always_comb begin
    unique case (op_i)
      OP_PROG:   edge_ok = (bits_i >= BITS_MIN) && (bits_i[2:0] == 3'd0);
      OP_BULK:   edge_ok = (bits_i == BITS_OPC);
      default:   edge_ok = (bits_i == BITS_ADDR);
    endcase
    region_ok = (op_i == OP_BULK) ? bp_none_i : !prot_hit_i;
  end

  assign accept_o = valid_i && !busy_i && wel_i && edge_ok && region_ok;
endmodule

// File: rtl/fws_pbuf.sv
module fws_pbuf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [7:0]        data_i,
  input  logic [PAGE_W-1:0] rd_slot_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_mask_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [PAGE_W-1:0] slot_q;
  logic [7:0]        byte_arr [SLOTS];
  logic              mask_arr [SLOTS];

  // slot index wraps with the page, so overflow bytes overwrite
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    slot_q <= '0;
    else if (clr_i) slot_q <= '0;
    else if (wr_i)  slot_q <= slot_q + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] b_q;
    logic       m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= '0;
        m_q <= 1'b0;
      end else if (clr_i) begin
        m_q <= 1'b0;
      end else if (wr_i && (slot_q == PAGE_W'(g))) begin
        b_q <= data_i;
        m_q <= 1'b1;
      end
    end
    assign byte_arr[g] = b_q;
    assign mask_arr[g] = m_q;
  end

  assign rd_data_o = byte_arr[rd_slot_i];
  assign rd_mask_o = mask_arr[rd_slot_i];
endmodule

// File: rtl/fws_timer.sv
module fws_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fws_walk.sv
module fws_walk #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] lim_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == lim_i);
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq import fws_pkg::*; #(
  parameter int PAGE_W   = 8,
  parameter int SECT_W   = 8,
  parameter int NSECT_W  = 2,
  parameter int BIT_W    = 16,
  parameter int CNT_W    = 32,
  // wait lengths in clocks, each at least 1
  parameter int T_PROG   = 800000,
  parameter int T_PERASE = 300000,
  parameter int T_SERASE = 50000000,
  parameter int T_BULK   = 200000000,
  localparam int ADDR_W  = NSECT_W + SECT_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_start_i,
  input  logic              dat_valid_i,
  input  logic [7:0]        dat_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BIT_W-1:0]  cmd_bits_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              wel_i,
  input  logic              prot_hit_i,
  input  logic              bp_none_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wel_clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int SPAN_W = PAGE_W + SECT_W;
  localparam logic [ADDR_W-1:0] LAST_PAGE = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] LAST_SECT = ADDR_W'((1 << SPAN_W) - 1);
  localparam logic [ADDR_W-1:0] LAST_ALL  = '1;

  st_e               st_q, st_d;
  op_e               op_q, cmd_op;
  logic [ADDR_W-1:0] addr_q;
  logic              busy, accept, t_exp, w_last, w_clr, w_step;
  logic [ADDR_W-1:0] w_cnt, w_lim;
  logic [CNT_W-1:0]  t_len;
  logic [7:0]        b_byte;
  logic              b_mask;
  logic [PAGE_W-1:0] pg_off;

  assign cmd_op = op_e'(cmd_op_i);
  assign busy   = (st_q != ST_IDLE);

  fws_gate #(.BIT_W(BIT_W)) u_gate (
    .valid_i    (cmd_valid_i),
    .busy_i     (busy),
    .op_i       (cmd_op),
    .bits_i     (cmd_bits_i),
    .wel_i      (wel_i),
    .prot_hit_i (prot_hit_i),
    .bp_none_i  (bp_none_i),
    .accept_o   (accept)
  );

  always_comb begin
    unique case (cmd_op)
      OP_PROG:   t_len = CNT_W'(T_PROG);
      OP_PERASE: t_len = CNT_W'(T_PERASE);
      OP_SERASE: t_len = CNT_W'(T_SERASE);
      default:   t_len = CNT_W'(T_BULK);
    endcase
  end

  fws_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (t_len),
    .exp_o  (t_exp)
  );

  always_comb begin
    unique case (op_q)
      OP_SERASE: w_lim = LAST_SECT;
      OP_BULK:   w_lim = LAST_ALL;
      default:   w_lim = LAST_PAGE;
    endcase
  end

  assign w_clr  = (st_q == ST_WAIT) && t_exp;
  assign w_step = (st_q == ST_WRITE);

  fws_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (w_clr),
    .step_i (w_step),
    .lim_i  (w_lim),
    .cnt_o  (w_cnt),
    .last_o (w_last)
  );

  fws_pbuf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_start_i && !busy),
    .wr_i      (dat_valid_i && !busy),
    .data_i    (dat_i),
    .rd_slot_i (w_cnt[PAGE_W-1:0]),
    .rd_data_o (b_byte),
    .rd_mask_o (b_mask)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_WAIT;
      ST_WAIT:  if (t_exp)  st_d = ST_WRITE;
      ST_WRITE: if (w_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q   <= cmd_op;
        addr_q <= cmd_addr_i;
      end
    end
  end

  // program offsets wrap inside the addressed page
  assign pg_off = addr_q[PAGE_W-1:0] + w_cnt[PAGE_W-1:0];

  always_comb begin
    unique case (op_q)
      OP_PROG:   mem_addr_o = {addr_q[ADDR_W-1:PAGE_W], pg_off};
      OP_PERASE: mem_addr_o = {addr_q[ADDR_W-1:PAGE_W], w_cnt[PAGE_W-1:0]};
      OP_SERASE: mem_addr_o = {addr_q[ADDR_W-1:SPAN_W], w_cnt[SPAN_W-1:0]};
      default:   mem_addr_o = w_cnt;
    endcase
  end

  assign mem_we_o    = (st_q == ST_WRITE) && ((op_q != OP_PROG) || b_mask);
  assign mem_wdata_o = (op_q == OP_PROG) ? (mem_rdata_i & b_byte) : 8'hFF;
  assign busy_o      = busy;
  assign done_o      = (st_q == ST_WRITE) && w_last;
  assign wel_clr_o   = done_o;
endmodule

// File: rtl/flash_wr_seq_chk.sv
module flash_wr_seq_chk #(
  parameter int BIT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic [BIT_W-1:0] cmd_bits_i,
  input logic             wel_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             wel_clr_o,
  input logic             mem_we_o,
  input logic [7:0]       mem_wdata_o,
  input logic [7:0]       mem_rdata_i
);
  p_edge_bulk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && ($past(cmd_op_i) == 2'd3) |-> $past(cmd_bits_i) == BIT_W'(8));

  p_start_needs_wel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i) && $past(wel_i));

  p_busy_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  p_only_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == 8'hFF) || ((mem_wdata_o & ~mem_rdata_i) == 8'h00));

  p_done_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_wel_clr_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> busy_o);

  p_we_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
endmodule

bind flash_wr_seq flash_wr_seq_chk #(.BIT_W(BIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_bits_i  (cmd_bits_i),
  .wel_i       (wel_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .wel_clr_o   (wel_clr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/flash_wr_seq_tb.sv
`timescale 1ns/1ps
module flash_wr_seq_tb;
  localparam int PW = 4, SW = 2, NW = 2, BW = 16, AW = PW + SW + NW;
  localparam int NB = 1 << AW, PG = 1 << PW, SEC = 1 << (PW + SW);
  localparam int TP = 20, TPE = 10, TSE = 12, TBK = 15;

  logic clk = 0, rst_n = 0;
  logic sel_start = 0, dat_valid = 0, cmd_valid = 0;
  logic [7:0] dat = 0;
  logic [1:0] cmd_op = 0;
  logic [BW-1:0] cmd_bits = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic wel = 0, prot_hit = 0, bp_none = 0;
  logic busy_o, done_o, wel_clr_o, mem_we_o;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [NB];
  logic [7:0] exp_m [NB];
  logic [7:0] q [$];
  int rem = 0, tests = 0, fails = 0;
  bit cmp_pend = 0;
  string cur_tag = "R6", cmp_tag = "R6";

  always #2.5 clk = ~clk;

  flash_wr_seq #(.PAGE_W(PW), .SECT_W(SW), .NSECT_W(NW), .BIT_W(BW), .CNT_W(8),
                 .T_PROG(TP), .T_PERASE(TPE), .T_SERASE(TSE), .T_BULK(TBK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_start_i(sel_start), .dat_valid_i(dat_valid),
    .dat_i(dat), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_bits_i(cmd_bits),
    .cmd_addr_i(cmd_addr), .wel_i(wel), .prot_hit_i(prot_hit), .bp_none_i(bp_none),
    .busy_o(busy_o), .done_o(done_o), .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'((i * 37 + 11) & 255);
    end else if (mem_we_o) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit acc_f(input int op, input int bits, input bit w, input bit ph, input bit bn);
    bit edge_ok, guard;
    if (op == 0)      edge_ok = (bits >= 40) && (bits % 8 == 0);
    else if (op == 3) edge_ok = (bits == 8);
    else              edge_ok = (bits == 32);
    guard = (op == 3) ? bn : !ph;
    return edge_ok && w && guard;
  endfunction

  task automatic apply(input int op, input int addr);
    logic [7:0] tmp [PG];
    bit v [PG];
    int base;
    case (op)
      0: begin
        for (int o = 0; o < PG; o++) v[o] = 0;
        for (int i = 0; i < q.size(); i++) begin
          tmp[((addr % PG) + i) % PG] = q[i];
          v[((addr % PG) + i) % PG] = 1;
        end
        base = addr - (addr % PG);
        for (int o = 0; o < PG; o++) if (v[o]) exp_m[base + o] = exp_m[base + o] & tmp[o];
        rem = TP + PG;
      end
      1: begin
        base = addr - (addr % PG);
        for (int o = 0; o < PG; o++) exp_m[base + o] = 8'hFF;
        rem = TPE + PG;
      end
      2: begin
        base = addr - (addr % SEC);
        for (int o = 0; o < SEC; o++) exp_m[base + o] = 8'hFF;
        rem = TSE + SEC;
      end
      default: begin
        for (int o = 0; o < NB; o++) exp_m[o] = 8'hFF;
        rem = TBK + NB;
      end
    endcase
  endtask

  // reference model: compare outputs, then step for the coming edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o === (rem > 0), "R4 busy", int'(busy_o), int'(rem > 0));
      chk(done_o === (rem == 1), "R9 done", int'(done_o), int'(rem == 1));
      chk(wel_clr_o === (rem == 1), "R9 wel_clr", int'(wel_clr_o), int'(rem == 1));
      chk(!(mem_we_o && rem == 0), "R10 we", int'(mem_we_o), 0);
      if (cmp_pend) begin
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < NB; i++)
          if (mem[i] !== exp_m[i]) begin
            bad++;
            if (first < 0) first = i;
          end
        if (first < 0) chk(1, cmp_tag, 0, 0);
        else chk(0, {cmp_tag, " mem"}, int'(mem[first]), int'(exp_m[first]));
        cmp_pend = 0;
      end
      if (rem > 0) begin
        rem--;
        if (rem == 0) cmp_pend = 1;
      end else begin
        if (sel_start) q.delete();
        if (dat_valid) q.push_back(dat);
        if (cmd_valid) begin
          cmp_tag = cur_tag;
          if (acc_f(cmd_op, cmd_bits, wel, prot_hit, bp_none)) apply(cmd_op, cmd_addr);
          else cmp_pend = 1;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    sel_start = 0; dat_valid = 0; cmd_valid = 0;
  endtask

  task automatic frame();
    sel_start = 1; tick();
  endtask

  task automatic put(input logic [7:0] b);
    dat_valid = 1; dat = b; tick();
  endtask

  task automatic cmd(input int op, input int bits, input int addr, input bit w,
                     input bit ph, input bit bn, input string tag);
    cmd_op = 2'(op); cmd_bits = BW'(bits); cmd_addr = AW'(addr);
    wel = w; prot_hit = ph; bp_none = bn; cur_tag = tag;
    cmd_valid = 1; tick();
  endtask

  task automatic settle();
    tick();
    while (rem != 0 || cmp_pend) tick();
    tick(); tick();
  endtask

  initial begin
    for (int i = 0; i < NB; i++) exp_m[i] = 8'((i * 37 + 11) & 255);
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && mem_we_o == 0, "R11 reset", int'({busy_o, done_o, mem_we_o}), 0);
    tick();

    // R6: three bytes mid-page
    frame(); put(8'h0F); put(8'hA5); put(8'h3C);
    cmd(0, 56, 'h25, 1, 0, 0, "R6"); settle();

    // R7: twenty bytes starting near page end wrap and overwrite
    frame();
    for (int i = 0; i < 20; i++) put(8'(8'hF0 ^ (i * 13)));
    cmd(0, 32 + 160, 'h3E, 1, 0, 0, "R7"); settle();

    // R1: program ending mid-byte, erase with extra bit, bulk after 16 bits
    frame(); put(8'h00);
    cmd(0, 43, 'h50, 1, 0, 0, "R1"); settle();
    frame(); cmd(1, 33, 'h47, 1, 0, 0, "R1"); settle();
    frame(); cmd(3, 16, 'h00, 1, 0, 1, "R1"); settle();

    // R8: page and sector erase
    frame(); cmd(1, 32, 'h47, 1, 0, 0, "R8"); settle();
    frame(); cmd(2, 32, 'h80, 1, 0, 0, "R8"); settle();

    // R2: latch clear drops commands
    frame(); cmd(3, 8, 'h00, 0, 0, 1, "R2"); settle();
    frame(); put(8'h00); cmd(0, 40, 'h10, 0, 0, 0, "R2"); settle();

    // R3: protection
    frame(); cmd(3, 8, 'h00, 1, 0, 0, "R3"); settle();
    frame(); put(8'h00); cmd(0, 40, 'h10, 1, 1, 0, "R3"); settle();
    frame(); cmd(2, 32, 'h10, 1, 1, 1, "R3"); settle();

    // R5: inputs during busy are ignored
    frame(); cmd(2, 32, 'hC5, 1, 0, 0, "R5");
    tick(); tick();
    frame(); put(8'hAA);
    cmd(1, 32, 'h00, 1, 0, 1, "R5");
    settle();
    put(8'h3C);
    cmd(0, 40, 'hC9, 1, 0, 0, "R5"); settle();

    // R6: program into erased bytes
    frame(); put(8'h5A); put(8'h81);
    cmd(0, 48, 'h4E, 1, 0, 0, "R6"); settle();

    // R8: whole-array erase
    frame(); cmd(3, 8, 'h00, 1, 0, 1, "R8"); settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule